// File: doc/BRIEF.md
# Next Program Counter and Branch Target Unit

This block computes the program counter that follows the current instruction in a small 8-bit controller core. The decode stage supplies the current PC, the length of the instruction in bytes, a 4-bit operation code, and the operands the instruction carries: a signed relative offset, an immediate target and a data pointer. It also supplies the values that conditional branches test: the accumulator, the carry flag, one selected bit, and two 8-bit operands for compare and decrement branches. From these the unit selects the next PC, reports whether control flow was redirected, and gives the return address to push for calls.

It also raises the side-effect requests that belong to control flow. These are a request to clear the tested bit, a carry write with its new value for compare branches, and the decremented byte with a write strobe for decrement branches. The fetch, decode and memory logic consume these requests. The unit itself does no fetching and no memory access. All outputs are registered, so results appear one clock after the inputs are presented.

Top module: `nextpc_unit`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. When no branch is taken, including op 0 (sequential), npc_o equals (pc_i + len_i) mod 65536 and taken_o is 0.
- R3: op 1 (unconditional relative) is always taken, with npc_o = (pc_i + len_i + sign-extended rel_i) mod 65536. Every conditional branch that is taken uses the same target.
- R4: The relative branches taken on a single condition are: op 2 when cy_i is 1, op 3 when cy_i is 0, op 4 when bit_i is 1, op 5 when bit_i is 0, op 7 when acc_i is 0, and op 8 when acc_i is not 0.
- R5: op 6 is taken when bit_i is 1. bit_clr_o is 1 exactly when this op is taken, and 0 for every other case.
- R6: op 9 is taken when opa_i differs from opb_i. It always sets cy_we_o to 1, with cy_o equal to 1 exactly when opa_i < opb_i as unsigned values. For every other op, cy_we_o and cy_o are 0.
- R7: op 10 sets dec_we_o to 1 with dec_val_o = (opa_i - 1) mod 256, and it is taken when that value is not 0. For every other op, dec_we_o and dec_val_o are 0.
- R8: op 11 (page jump) and op 12 (page call) are always taken. npc_o keeps bits 15..11 of pc_i + len_i and takes bits 10..0 from imm_i.
- R9: op 13 (far jump) and op 14 (far call) are always taken, with npc_o = imm_i.
- R10: For op 12 and op 14, push_o is 1 and ret_addr_o = (pc_i + len_i) mod 65536. For all other ops, push_o and ret_addr_o are 0.
- R11: op 15 (indirect jump) is always taken, with npc_o = (dptr_i + zero-extended acc_i) mod 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 16 | Address of the current instruction |
| len_i | input | 2 | Instruction length in bytes |
| op_i | input | 4 | Control-flow operation code |
| rel_i | input | 8 | Signed relative offset |
| imm_i | input | 16 | Absolute target; the low 11 bits serve as the in-page target |
| dptr_i | input | 16 | Data pointer for the indirect jump |
| acc_i | input | 8 | Accumulator value |
| cy_i | input | 1 | Carry flag value |
| bit_i | input | 1 | Value of the selected bit |
| opa_i | input | 8 | Compare first operand, or the operand to decrement |
| opb_i | input | 8 | Compare second operand |
| npc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Control flow redirected |
| push_o | output | 1 | Call: push the return address |
| ret_addr_o | output | 16 | Return address for calls |
| bit_clr_o | output | 1 | Request to clear the tested bit |
| cy_we_o | output | 1 | Carry write strobe |
| cy_o | output | 1 | New carry value |
| dec_we_o | output | 1 | Decremented value write strobe |
| dec_val_o | output | 8 | Decremented operand |

## Verification
The bench builds the unit with its default parameters: a 16-bit PC, 8-bit data and an 11-bit page field. These values make the page boundary at 0x0800 and the wrap at 0xFFFF reachable with single vectors. Directed vectors cover the offset extremes -128 and +127, a next-instruction address that crosses into a new page, an indirect sum that overflows 16 bits, and decrement operands of 0 and 1. Random vectors are biased toward equal compare operands and a zero accumulator, so that both outcomes of every condition occur many times.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ   = 4'd0,
        OP_BRA   = 4'd1,
        OP_BCS   = 4'd2,
        OP_BCC   = 4'd3,
        OP_BBS   = 4'd4,
        OP_BBC   = 4'd5,
        OP_BBSC  = 4'd6,
        OP_BAZ   = 4'd7,
        OP_BANZ  = 4'd8,
        OP_CMPNE = 4'd9,
        OP_DECNZ = 4'd10,
        OP_PJMP  = 4'd11,
        OP_PCALL = 4'd12,
        OP_FJMP  = 4'd13,
        OP_FCALL = 4'd14,
        OP_IJMP  = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        SEL_SEQ,
        SEL_REL,
        SEL_PAGE,
        SEL_ABS,
        SEL_IND
    } sel_e;

endpackage

// File: rtl/nextpc_target.sv
module nextpc_target #(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11,
    parameter int LEN_W  = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [LEN_W-1:0] len,
    input  logic [DW-1:0]    rel,
    input  logic [PC_W-1:0]  imm,
    input  logic [PC_W-1:0]  dptr,
    input  logic [DW-1:0]    acc,
    output logic [PC_W-1:0]  seq_addr,
    output logic [PC_W-1:0]  rel_addr,
    output logic [PC_W-1:0]  page_addr,
    output logic [PC_W-1:0]  ind_addr
);

    localparam int EXT_W = PC_W - DW;

    logic [PC_W-1:0] rel_ext;

    always_comb begin
        seq_addr = pc + PC_W'(len);
        rel_ext  = {{EXT_W{rel[DW-1]}}, rel};
        rel_addr = seq_addr + rel_ext;
        ind_addr = dptr + PC_W'(acc);
    end

    generate
        if (PAGE_W >= PC_W) begin : g_flat
            assign page_addr = imm;
        end else begin : g_paged
            assign page_addr = {seq_addr[PC_W-1:PAGE_W], imm[PAGE_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
    import nextpc_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic          cy,
    input  logic          bitv,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          take,
    output sel_e          sel,
    output logic          push,
    output logic          bit_clr,
    output logic          cy_we,
    output logic          cy_val,
    output logic          dec_we,
    output logic [DW-1:0] dec_val
);

    logic          acc_zero;
    logic [DW-1:0] dec_res;

    always_comb begin
        acc_zero = (acc == '0);
        dec_res  = opa - DW'(1);
        take     = 1'b0;
        sel      = SEL_REL;
        push     = 1'b0;
        bit_clr  = 1'b0;
        cy_we    = 1'b0;
        cy_val   = 1'b0;
        dec_we   = 1'b0;
        dec_val  = '0;
        unique case (op)
            OP_SEQ:   sel  = SEL_SEQ;
            OP_BRA:   take = 1'b1;
            OP_BCS:   take = cy;
            OP_BCC:   take = ~cy;
            OP_BBS:   take = bitv;
            OP_BBC:   take = ~bitv;
            OP_BBSC: begin
                take    = bitv;
                bit_clr = bitv;
            end
            OP_BAZ:   take = acc_zero;
            OP_BANZ:  take = ~acc_zero;
            OP_CMPNE: begin
                take   = (opa != opb);
                cy_we  = 1'b1;
                cy_val = (opa < opb);
            end
            OP_DECNZ: begin
                dec_we  = 1'b1;
                dec_val = dec_res;
                take    = (dec_res != '0);
            end
            OP_PJMP: begin
                take = 1'b1;
                sel  = SEL_PAGE;
            end
            OP_PCALL: begin
                take = 1'b1;
                sel  = SEL_PAGE;
                push = 1'b1;
            end
            OP_FJMP: begin
                take = 1'b1;
                sel  = SEL_ABS;
            end
            OP_FCALL: begin
                take = 1'b1;
                sel  = SEL_ABS;
                push = 1'b1;
            end
            OP_IJMP: begin
                take = 1'b1;
                sel  = SEL_IND;
            end
            default: sel = SEL_SEQ;
        endcase
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DW-1:0]     rel_i,
    input  logic [PC_W-1:0]   imm_i,
    input  logic [PC_W-1:0]   dptr_i,
    input  logic [DW-1:0]     acc_i,
    input  logic              cy_i,
    input  logic              bit_i,
    input  logic [DW-1:0]     opa_i,
    input  logic [DW-1:0]     opb_i,
    output logic [PC_W-1:0]   npc_o,
    output logic              taken_o,
    output logic              push_o,
    output logic [PC_W-1:0]   ret_addr_o,
    output logic              bit_clr_o,
    output logic              cy_we_o,
    output logic              cy_o,
    output logic              dec_we_o,
    output logic [DW-1:0]     dec_val_o
);

    typedef struct packed {
        logic [PC_W-1:0] npc;
        logic            taken;
        logic            push;
        logic [PC_W-1:0] ret;
        logic            bclr;
        logic            cwe;
        logic            cval;
        logic            dwe;
        logic [DW-1:0]   dval;
    } out_t;

    out_t st_d, st_q;

    logic [PC_W-1:0] seq_addr, rel_addr, page_addr, ind_addr;
    logic            take, push, bclr, cwe, cval, dwe;
    logic [DW-1:0]   dval;
    sel_e            sel;

    nextpc_target #(
        .PC_W  (PC_W),
        .DW    (DW),
        .PAGE_W(PAGE_W),
        .LEN_W (LEN_W)
    ) target_i (
        .pc       (pc_i),
        .len      (len_i),
        .rel      (rel_i),
        .imm      (imm_i),
        .dptr     (dptr_i),
        .acc      (acc_i),
        .seq_addr (seq_addr),
        .rel_addr (rel_addr),
        .page_addr(page_addr),
        .ind_addr (ind_addr)
    );

    nextpc_cond #(
        .DW(DW)
    ) cond_i (
        .op     (op_e'(op_i)),
        .cy     (cy_i),
        .bitv   (bit_i),
        .acc    (acc_i),
        .opa    (opa_i),
        .opb    (opb_i),
        .take   (take),
        .sel    (sel),
        .push   (push),
        .bit_clr(bclr),
        .cy_we  (cwe),
        .cy_val (cval),
        .dec_we (dwe),
        .dec_val(dval)
    );

    always_comb begin
        st_d       = '0;
        st_d.taken = take;
        st_d.npc   = seq_addr;
        if (take) begin
            unique case (sel)
                SEL_REL:  st_d.npc = rel_addr;
                SEL_PAGE: st_d.npc = page_addr;
                SEL_ABS:  st_d.npc = imm_i;
                SEL_IND:  st_d.npc = ind_addr;
                default:  st_d.npc = seq_addr;
            endcase
        end
        st_d.push = push;
        st_d.ret  = push ? seq_addr : '0;
        st_d.bclr = bclr;
        st_d.cwe  = cwe;
        st_d.cval = cval;
        st_d.dwe  = dwe;
        st_d.dval = dval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign npc_o      = st_q.npc;
    assign taken_o    = st_q.taken;
    assign push_o     = st_q.push;
    assign ret_addr_o = st_q.ret;
    assign bit_clr_o  = st_q.bclr;
    assign cy_we_o    = st_q.cwe;
    assign cy_o       = st_q.cval;
    assign dec_we_o   = st_q.dwe;
    assign dec_val_o  = st_q.dval;

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc_i,
    input logic [LEN_W-1:0]  len_i,
    input logic [3:0]        op_i,
    input logic [DW-1:0]     opa_i,
    input logic [DW-1:0]     opb_i,
    input logic [PC_W-1:0]   npc_o,
    input logic              taken_o,
    input logic              push_o,
    input logic [PC_W-1:0]   ret_addr_o,
    input logic              bit_clr_o,
    input logic              cy_we_o,
    input logic              cy_o,
    input logic              dec_we_o,
    input logic [DW-1:0]     dec_val_o
);

    logic [PC_W-1:0] nxt;
    logic            page_op;
    assign nxt     = pc_i + PC_W'(len_i);
    assign page_op = (op_i == 4'd11) || (op_i == 4'd12);

    assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (npc_o == $past(nxt)));

    assert_clear_only_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clr_o |-> taken_o);

    assert_cmp_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cy_we_o) |-> (cy_o == ($past(opa_i) < $past(opb_i))));

    assert_dec_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dec_we_o) |->
            ((dec_val_o == DW'($past(opa_i) - DW'(1))) && (taken_o == (dec_val_o != '0))));

    assert_page_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(page_op)) |->
            (npc_o[PC_W-1:PAGE_W] == $past(nxt[PC_W-1:PAGE_W])));

    assert_push_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && push_o) |-> (ret_addr_o == $past(nxt)));

    assert_idle_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !push_o |-> (ret_addr_o == '0));

endmodule

bind nextpc_unit nextpc_unit_chk #(
    .PC_W  (PC_W),
    .DW    (DW),
    .PAGE_W(PAGE_W),
    .LEN_W (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_i      (pc_i),
    .len_i     (len_i),
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .npc_o     (npc_o),
    .taken_o   (taken_o),
    .push_o    (push_o),
    .ret_addr_o(ret_addr_o),
    .bit_clr_o (bit_clr_o),
    .cy_we_o   (cy_we_o),
    .cy_o      (cy_o),
    .dec_we_o  (dec_we_o),
    .dec_val_o (dec_val_o)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0;
    logic [1:0]  len_i = '0;
    logic [3:0]  op_i = '0;
    logic [7:0]  rel_i = '0;
    logic [15:0] imm_i = '0;
    logic [15:0] dptr_i = '0;
    logic [7:0]  acc_i = '0;
    logic        cy_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [7:0]  opa_i = '0;
    logic [7:0]  opb_i = '0;
    logic [15:0] npc_o, ret_addr_o;
    logic        taken_o, push_o, bit_clr_o, cy_we_o, cy_o, dec_we_o;
    logic [7:0]  dec_val_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nextpc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .len_i(len_i), .op_i(op_i),
        .rel_i(rel_i), .imm_i(imm_i), .dptr_i(dptr_i), .acc_i(acc_i),
        .cy_i(cy_i), .bit_i(bit_i), .opa_i(opa_i), .opb_i(opb_i),
        .npc_o(npc_o), .taken_o(taken_o), .push_o(push_o),
        .ret_addr_o(ret_addr_o), .bit_clr_o(bit_clr_o), .cy_we_o(cy_we_o),
        .cy_o(cy_o), .dec_we_o(dec_we_o), .dec_val_o(dec_val_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd6: return "R5";
            4'd9: return "R6";
            4'd10: return "R7";
            4'd11, 4'd12: return "R8";
            4'd13, 4'd14: return "R9";
            4'd15: return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (op %0d)", req, what, act, exp, op_i);
        end
    endtask

    task automatic run_vec();
        logic [15:0] nxt, e_npc, e_ret;
        logic [7:0]  dv;
        logic        tk, e_push, e_clr, e_cwe, e_cy, e_dwe;
        logic [7:0]  e_dval;
        nxt    = pc_i + {14'd0, len_i};
        dv     = opa_i - 8'd1;
        tk     = 1'b0; e_push = 1'b0; e_clr = 1'b0; e_cwe = 1'b0;
        e_cy   = 1'b0; e_dwe = 1'b0; e_dval = 8'd0;
        e_npc  = nxt;
        case (op_i)
            4'd1: tk = 1'b1;
            4'd2: tk = cy_i;
            4'd3: tk = !cy_i;
            4'd4: tk = bit_i;
            4'd5: tk = !bit_i;
            4'd6: begin tk = bit_i; e_clr = bit_i; end
            4'd7: tk = (acc_i == 8'd0);
            4'd8: tk = (acc_i != 8'd0);
            4'd9: begin tk = (opa_i != opb_i); e_cwe = 1'b1; e_cy = (opa_i < opb_i); end
            4'd10: begin e_dwe = 1'b1; e_dval = dv; tk = (dv != 8'd0); end
            default: tk = (op_i != 4'd0);
        endcase
        if (tk) begin
            if (op_i <= 4'd10) e_npc = nxt + {{8{rel_i[7]}}, rel_i};
            else if (op_i <= 4'd12) e_npc = {nxt[15:11], imm_i[10:0]};
            else if (op_i <= 4'd14) e_npc = imm_i;
            else e_npc = dptr_i + {8'd0, acc_i};
        end
        e_push = (op_i == 4'd12) || (op_i == 4'd14);
        e_ret  = e_push ? nxt : 16'd0;
        @(posedge clk);
        @(negedge clk);
        cmp(req_of(op_i), "npc", npc_o, e_npc);
        cmp(req_of(op_i), "taken", {15'd0, taken_o}, {15'd0, tk});
        cmp("R10", "push", {15'd0, push_o}, {15'd0, e_push});
        cmp("R10", "ret", ret_addr_o, e_ret);
        cmp("R5", "bitclr", {15'd0, bit_clr_o}, {15'd0, e_clr});
        cmp("R6", "carry", {14'd0, cy_we_o, cy_o}, {14'd0, e_cwe, e_cy});
        cmp("R7", "dec", {7'd0, dec_we_o, dec_val_o}, {7'd0, e_dwe, e_dval});
    endtask

    task automatic set_vec(input logic [3:0] op, input logic [15:0] pc, input logic [1:0] len,
                           input logic [7:0] rel, input logic [15:0] imm);
        op_i = op; pc_i = pc; len_i = len; rel_i = rel; imm_i = imm;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        set_vec(4'd13, 16'h1234, 2'd3, 8'h10, 16'hBEEF);
        acc_i = 8'h55; opa_i = 8'd3; opb_i = 8'd7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while reset is held
        cmp("R1", "npc", npc_o, 16'd0);
        cmp("R1", "flags", {7'd0, taken_o, push_o, bit_clr_o, cy_we_o, cy_o, dec_we_o, dec_val_o[1:0]}, 16'd0);
        cmp("R1", "ret", ret_addr_o, 16'd0);
        rst_n = 1'b1;

        // R3 offset extremes
        set_vec(4'd1, 16'h0100, 2'd2, 8'h80, 16'd0); run_vec();
        set_vec(4'd1, 16'h0100, 2'd2, 8'h7F, 16'd0); run_vec();
        set_vec(4'd1, 16'hFFFE, 2'd3, 8'h05, 16'd0); run_vec();
        // R2 sequential wrap
        set_vec(4'd0, 16'hFFFF, 2'd1, 8'h00, 16'd0); run_vec();
        // R8 next address crossing into a new page
        set_vec(4'd11, 16'h07FE, 2'd2, 8'h00, 16'h0123); run_vec();
        set_vec(4'd12, 16'hF7FF, 2'd2, 8'h00, 16'hFFFF); run_vec();
        // R9, R10 far call
        set_vec(4'd14, 16'hFFFE, 2'd3, 8'h00, 16'h4000); run_vec();
        // R11 indirect overflow
        dptr_i = 16'hFFF0; acc_i = 8'h20;
        set_vec(4'd15, 16'h0200, 2'd1, 8'h00, 16'd0); run_vec();
        // R7 decrement to zero and through zero
        opa_i = 8'd1; set_vec(4'd10, 16'h0300, 2'd2, 8'hF0, 16'd0); run_vec();
        opa_i = 8'd0; set_vec(4'd10, 16'h0300, 2'd3, 8'hF0, 16'd0); run_vec();
        // R6 equal, less, greater
        opa_i = 8'h40; opb_i = 8'h40; set_vec(4'd9, 16'h0400, 2'd3, 8'h08, 16'd0); run_vec();
        opa_i = 8'h3F; opb_i = 8'h40; run_vec();
        opa_i = 8'hFF; opb_i = 8'h00; run_vec();
        // R5 set and clear bit
        bit_i = 1'b1; set_vec(4'd6, 16'h0500, 2'd3, 8'hFE, 16'd0); run_vec();
        bit_i = 1'b0; run_vec();
        // R4 zero accumulator
        acc_i = 8'd0; set_vec(4'd7, 16'h0600, 2'd2, 8'h22, 16'd0); run_vec();
        set_vec(4'd8, 16'h0600, 2'd2, 8'h22, 16'd0); run_vec();

        for (int i = 0; i < 3000; i++) begin
            op_i   = 4'($urandom_range(0, 15));
            pc_i   = 16'($urandom);
            len_i  = (op_i == 4'd0) ? 2'($urandom_range(1, 3)) : 2'($urandom_range(2, 3));
            rel_i  = 8'($urandom);
            imm_i  = 16'($urandom);
            dptr_i = 16'($urandom);
            acc_i  = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
            cy_i   = 1'($urandom);
            bit_i  = 1'($urandom);
            opa_i  = ($urandom_range(0, 3) == 0) ? 8'd1 : 8'($urandom);
            opb_i  = ($urandom_range(0, 3) == 0) ? opa_i : 8'($urandom);
            run_vec();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule